// File: doc/BRIEF.md
# Double-Edge Strobe Burst Sender

This block sends a burst of 16-bit words over a parallel data bus and marks each word with one transition of a single strobe line. Rising and falling transitions both carry data, so the strobe runs at half the word rate. A start pulse begins a burst and supplies the number of words and a timing mode. Words arrive from an upstream stream with a valid/ready handshake. When the last word has been held long enough, a one-cycle done flag is raised and the strobe goes back to its idle level.

All timing is set by nanosecond minimums for each mode. The block turns each one into a count of system clock cycles, rounding up, with `CLK_PERIOD_NS` as a parameter. Four rules bound each strobe transition. The word must have been stable for a setup window before the transition. The transition must not come too soon after the previous one. It must not come too soon after the transition two steps back, which had the same direction. After each transition the bus must stay unchanged for a short hold window. The block issues each transition in the first cycle in which all of these rules are met.

Top module: `dstrobe_burst_tx`

## Requirements
- R1: After reset the strobe is high, the data bus is zero, done is low and the input stream is not accepted (ready low).
- R2: A burst of N words gives exactly N strobe transitions. The first is falling and later ones alternate direction. At each transition the bus carries the next accepted word in order. The strobe changes at no other time except the return to high when done is raised.
- R3: The word is on the bus at least S cycles before the transition that marks it. S is ceil(70, 48, 34 ns / CLK_PERIOD_NS) for mode codes 0, 1, 2. Mode code 3 behaves as code 2 for every limit.
- R4: Two consecutive transitions are at least E cycles apart, where E is ceil(114, 75, 55 ns / CLK_PERIOD_NS) for modes 0, 1, 2.
- R5: Two transitions of the same direction are at least P cycles apart, where P is ceil(235, 156, 117 ns / CLK_PERIOD_NS). This is checked separately from R4.
- R6: The bus does not change for H cycles after a transition, where H is ceil(6 ns / CLK_PERIOD_NS). Ready is raised only when the next load would land at or after that point.
- R7: If words are always available, transition i occurs at k_i = max(d_i+S, k_(i-1)+E, k_(i-2)+P) cycles after the start edge. Here d_0 = 1 and d_i = k_(i-1)+H.
- R8: If no word is offered, the strobe and the bus keep their levels. The next transition comes in the first cycle allowed by the load time of its word and by the recorded times of the last two transitions.
- R9: Done is high for exactly one cycle, H cycles after the final transition, and the strobe is high in that cycle.
- R10: The mode and word count are captured on the start pulse. A change of the mode input, or a further start pulse, during a burst has no effect.
- R11: A start pulse with a word count of zero is ignored: no ready, no transition and no done.
- R12: Every derived cycle count is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only while idle |
| mode_i | input | 2 | Timing mode code (0, 1, 2; 3 acts as 2) |
| count_i | input | CNT_W | Number of words in the burst |
| in_valid_i | input | 1 | Upstream word valid |
| in_data_i | input | DATA_W | Upstream word |
| in_ready_o | output | 1 | Block accepts a word this cycle |
| data_o | output | DATA_W | Parallel data bus |
| strobe_o | output | 1 | Double-edge strobe, idles high |
| done_o | output | 1 | One-cycle end-of-burst flag |

## Verification
Every mode code, including the alias code, is run with burst lengths of one to four words. Each run is done once with a stream that never stalls and once with a stream that stays silent for long stretches. The stall-free runs compare every transition time with the closed-form schedule, which shows which of the setup, spacing and same-direction limits is the binding one. Bursts of three or more words in mode 0 make the same-direction limit dominate. The stalled runs check that levels hold while the stream is silent and that the timing restarts from the load time and the recorded transitions. Separate runs change the mode input and repeat the start pulse mid-burst, and send a zero-length start, to show that those inputs are ignored.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_TAIL  = 2'd3
  } dsb_state_e;

  localparam int unsigned NUM_MODE_CODES = 4;
  localparam int unsigned NUM_LIMITS     = 4;
  localparam int unsigned LIM_GAP        = 0;
  localparam int unsigned LIM_PAIR       = 1;
  localparam int unsigned LIM_SETUP      = 2;
  localparam int unsigned LIM_HOLD       = 3;

  // Minimum in nanoseconds for a mode code and a limit kind; code 3 aliases code 2.
  function automatic int unsigned limit_ns(input int unsigned mode, input int unsigned kind);
    int unsigned m;
    m = (mode > 2) ? 2 : mode;
    case (kind)
      LIM_GAP:   return (m == 0) ? 114 : (m == 1) ? 75  : 55;
      LIM_PAIR:  return (m == 0) ? 235 : (m == 1) ? 156 : 117;
      LIM_SETUP: return (m == 0) ? 70  : (m == 1) ? 48  : 34;
      default:   return 6;
    endcase
  endfunction

  // Ceiling division to whole clock cycles, never below one cycle.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period_ns);
    int unsigned c;
    if (period_ns == 0) return (ns == 0) ? 1 : ns;
    c = (ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

  // Timer width: the largest count plus one spare value for saturation.
  function automatic int unsigned timer_width(input int unsigned period_ns);
    int unsigned mx;
    mx = 1;
    for (int unsigned m = 0; m < NUM_MODE_CODES; m++) begin
      for (int unsigned k = 0; k < NUM_LIMITS; k++) begin
        if (ns_to_cycles(limit_ns(m, k), period_ns) > mx) mx = ns_to_cycles(limit_ns(m, k), period_ns);
      end
    end
    return $clog2(mx + 2);
  endfunction

endpackage

// File: rtl/dsb_mode_limits.sv
module dsb_mode_limits #(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned TW            = 6
) (
  input  logic [1:0]    mode_i,
  output logic [TW-1:0] gap_o,
  output logic [TW-1:0] pair_o,
  output logic [TW-1:0] setup_o,
  output logic [TW-1:0] hold_o
);

  logic [TW-1:0] tbl [dsb_pkg::NUM_MODE_CODES][dsb_pkg::NUM_LIMITS];

  for (genvar m = 0; m < int'(dsb_pkg::NUM_MODE_CODES); m++) begin : g_mode
    for (genvar k = 0; k < int'(dsb_pkg::NUM_LIMITS); k++) begin : g_kind
      localparam int unsigned CYC =
        dsb_pkg::ns_to_cycles(dsb_pkg::limit_ns(m, k), CLK_PERIOD_NS);
      assign tbl[m][k] = TW'(CYC);
    end
  end

  assign gap_o   = tbl[mode_i][dsb_pkg::LIM_GAP];
  assign pair_o  = tbl[mode_i][dsb_pkg::LIM_PAIR];
  assign setup_o = tbl[mode_i][dsb_pkg::LIM_SETUP];
  assign hold_o  = tbl[mode_i][dsb_pkg::LIM_HOLD];

endmodule

// File: rtl/dsb_sat_timer.sv
module dsb_sat_timer #(
  parameter int unsigned TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic [TW-1:0] count_o
);

  localparam logic [TW-1:0] TOP = '1;

  // Counts clock edges since the last load; resets to "long ago".
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             count_o <= TOP;
    else if (load_i)         count_o <= load_val_i;
    else if (count_o != TOP) count_o <= count_o + 1'b1;
  end

endmodule

// File: rtl/dstrobe_burst_tx.sv
module dstrobe_burst_tx #(
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned CLK_PERIOD_NS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic [DATA_W-1:0] data_o,
  output logic              strobe_o,
  output logic              done_o
);

  import dsb_pkg::*;

  localparam int unsigned   TW      = timer_width(CLK_PERIOD_NS);
  localparam logic [TW-1:0] TMR_SAT = '1;
  localparam int unsigned   NUM_TMR = 3;
  localparam int unsigned   T_DATA  = 0;  // since the word was loaded
  localparam int unsigned   T_LAST  = 1;  // since the latest transition
  localparam int unsigned   T_PREV  = 2;  // since the transition before it

  // Elapsed count (value in the cycle before an edge) meets a minimum at that edge.
  function automatic logic reached(input logic [TW-1:0] elapsed, input logic [TW-1:0] need);
    return ({1'b0, elapsed} + 1'b1) >= {1'b0, need};
  endfunction

  function automatic logic [TW-1:0] sat_inc(input logic [TW-1:0] v);
    return (v == TMR_SAT) ? TMR_SAT : v + 1'b1;
  endfunction

  dsb_state_e        state_q;
  logic [1:0]        mode_q;
  logic [CNT_W-1:0]  left_q;
  logic [1:0]        nedge_q;
  logic              strobe_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q;

  logic [TW-1:0] gap_cyc, pair_cyc, setup_cyc, hold_cyc;

  logic [TW-1:0] tmr_cnt  [NUM_TMR];
  logic          tmr_load [NUM_TMR];
  logic [TW-1:0] tmr_val  [NUM_TMR];

  // Named internal events, used by the bound checker.
  logic burst_start, fetch_fire, edge_fire, tail_done;
  logic hold_met, setup_met, gap_met, pair_met;

  dsb_mode_limits #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .TW           (TW)
  ) u_limits (
    .mode_i (mode_q),
    .gap_o  (gap_cyc),
    .pair_o (pair_cyc),
    .setup_o(setup_cyc),
    .hold_o (hold_cyc)
  );

  for (genvar i = 0; i < int'(NUM_TMR); i++) begin : g_tmr
    dsb_sat_timer #(.TW(TW)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (tmr_load[i]),
      .load_val_i(tmr_val[i]),
      .count_o   (tmr_cnt[i])
    );
  end

  assign hold_met  = (nedge_q == 2'd0) || reached(tmr_cnt[T_LAST], hold_cyc);
  assign setup_met = reached(tmr_cnt[T_DATA], setup_cyc);
  assign gap_met   = (nedge_q == 2'd0) || reached(tmr_cnt[T_LAST], gap_cyc);
  assign pair_met  = (nedge_q != 2'd2) || reached(tmr_cnt[T_PREV], pair_cyc);

  assign burst_start = (state_q == ST_IDLE) && start_i && (count_i != '0);
  assign in_ready_o  = (state_q == ST_FETCH) && hold_met;
  assign fetch_fire  = in_ready_o && in_valid_i;
  assign edge_fire   = (state_q == ST_WAIT) && setup_met && gap_met && pair_met;
  assign tail_done   = (state_q == ST_TAIL) && hold_met;

  always_comb begin
    tmr_load[T_DATA] = fetch_fire;
    tmr_val[T_DATA]  = '0;
    tmr_load[T_LAST] = edge_fire;
    tmr_val[T_LAST]  = '0;
    tmr_load[T_PREV] = edge_fire;
    tmr_val[T_PREV]  = sat_inc(tmr_cnt[T_LAST]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= '0;
      left_q   <= '0;
      nedge_q  <= '0;
      strobe_q <= 1'b1;
      data_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= tail_done;
      unique case (state_q)
        ST_IDLE: begin
          if (burst_start) begin
            mode_q  <= mode_i;
            left_q  <= count_i;
            nedge_q <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fetch_fire) begin
            data_q  <= in_data_i;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (edge_fire) begin
            strobe_q <= ~strobe_q;
            left_q   <= left_q - 1'b1;
            if (nedge_q != 2'd2) nedge_q <= nedge_q + 1'b1;
            state_q  <= (left_q == CNT_W'(1)) ? ST_TAIL : ST_FETCH;
          end
        end
        ST_TAIL: begin
          if (tail_done) begin
            strobe_q <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o   = data_q;
  assign strobe_o = strobe_q;
  assign done_o   = done_q;

endmodule

// File: rtl/dstrobe_burst_tx_chk.sv
module dstrobe_burst_tx_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TW     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_o,
  input logic              done_o,
  input logic [DATA_W-1:0] data_o,
  input logic              edge_fire,
  input logic              burst_start,
  input logic [TW-1:0]     setup_cyc,
  input logic [TW-1:0]     gap_cyc,
  input logic [TW-1:0]     pair_cyc,
  input logic [TW-1:0]     hold_cyc
);

  localparam logic [TW-1:0] SAT = '1;

  logic [DATA_W-1:0] data_prev;
  logic [TW-1:0]     data_age, fire_age, fire_age2, cur_age;
  logic [1:0]        fires;
  logic              data_moved;
  logic              setup_ok, gap_ok, pair_ok;

  assign data_moved = (data_o != data_prev);
  assign cur_age    = data_moved ? '0 : data_age;
  assign setup_ok   = ({1'b0, cur_age} + 1'b1) >= {1'b0, setup_cyc};
  assign gap_ok     = ({1'b0, fire_age} + 1'b1) >= {1'b0, gap_cyc};
  assign pair_ok    = ({1'b0, fire_age2} + 1'b1) >= {1'b0, pair_cyc};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_prev <= '0;
      data_age  <= SAT;
      fire_age  <= SAT;
      fire_age2 <= SAT;
      fires     <= '0;
    end else begin
      data_prev <= data_o;
      if (data_moved)           data_age <= {{(TW-1){1'b0}}, 1'b1};
      else if (data_age != SAT) data_age <= data_age + 1'b1;
      if (edge_fire) begin
        fire_age  <= '0;
        fire_age2 <= (fire_age == SAT) ? SAT : fire_age + 1'b1;
      end else begin
        if (fire_age != SAT)  fire_age  <= fire_age + 1'b1;
        if (fire_age2 != SAT) fire_age2 <= fire_age2 + 1'b1;
      end
      if (burst_start)                    fires <= '0;
      else if (edge_fire && fires != 2'd2) fires <= fires + 1'b1;
    end
  end

  AST_SETUP_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_fire |-> setup_ok); // R3

  AST_EDGE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_fire && fires != 2'd0) |-> gap_ok); // R4

  AST_PAIR_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_fire && fires == 2'd2) |-> pair_ok); // R5

  AST_HOLD_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_moved |-> (fire_age >= hold_cyc)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_STROBE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> strobe_o); // R9

  AST_STROBE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != $past(strobe_o)) |-> ($past(edge_fire) || done_o)); // R2

  AST_LIMITS_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_cyc != '0) && (gap_cyc != '0) && (pair_cyc != '0) && (hold_cyc != '0)); // R12

endmodule

bind dstrobe_burst_tx dstrobe_burst_tx_chk #(
  .DATA_W(DATA_W),
  .TW    (TW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strobe_o   (strobe_o),
  .done_o     (done_o),
  .data_o     (data_o),
  .edge_fire  (edge_fire),
  .burst_start(burst_start),
  .setup_cyc  (setup_cyc),
  .gap_cyc    (gap_cyc),
  .pair_cyc   (pair_cyc),
  .hold_cyc   (hold_cyc)
);

// File: tb/test_dstrobe_burst_tx.sv
`timescale 1ns/1ps
module test_dstrobe_burst_tx;

  localparam int PER_NS = 5;
  localparam int DW     = 16;
  localparam int CW     = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic [CW-1:0] count_i = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready_o;
  logic [DW-1:0] data_o;
  logic          strobe_o;
  logic          done_o;

  always #2.5 clk = ~clk;

  dstrobe_burst_tx #(.DATA_W(DW), .CNT_W(CW), .CLK_PERIOD_NS(PER_NS)) i_dstrobe_burst_tx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i), .count_i(count_i),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready_o),
    .data_o(data_o), .strobe_o(strobe_o), .done_o(done_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 spacing, 1 same-direction, 2 setup, 3 hold
  function automatic int need(input int m, input int kind);
    int ns;
    int mm;
    int c;
    mm = (m > 2) ? 2 : m;
    case (kind)
      0:       ns = (mm == 0) ? 114 : (mm == 1) ? 75 : 55;
      1:       ns = (mm == 0) ? 235 : (mm == 1) ? 156 : 117;
      2:       ns = (mm == 0) ? 70 : (mm == 1) ? 48 : 34;
      default: ns = 6;
    endcase
    c = (ns + PER_NS - 1) / PER_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [DW-1:0] word(input int b, input int i);
    return {8'(b) ^ 8'h5A, 8'(i * 37) ^ 8'hC3};
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Shared run state
  int edge_t [16];
  int edges = 0, last_load = 0, n_words = 0, burst_id = 0, src_idx = 0, done_cyc = 0;
  int S = 1, E = 1, P = 1, H = 1;
  bit src_fire = 0, src_on = 0, stall = 0, mon_on = 0, done_seen = 0;
  bit watch = 0;
  logic          w_strobe;
  logic [DW-1:0] w_data;
  logic          prev_strobe = 1'b1;
  logic [DW-1:0] prev_data = '0;

  // Monitor and stream source, all at the falling edge.
  always @(negedge clk) begin
    if (watch) begin
      chk(strobe_o == w_strobe && data_o == w_data, "R8 levels held while stalled",
          int'({strobe_o, data_o}), int'({w_strobe, w_data}));
      watch = 0;
    end
    if (mon_on) begin
      if (strobe_o !== prev_strobe && !done_o) begin
        int lim;
        chk(strobe_o == ((edges % 2) == 1), "R2 direction", int'(strobe_o), edges % 2);
        chk(data_o == word(burst_id, edges), "R2 word order", int'(data_o), int'(word(burst_id, edges)));
        chk(cyc - last_load >= S, "R3 setup", cyc - last_load, S);
        lim = last_load + S;
        if (edges >= 1) begin
          chk(cyc - edge_t[edges-1] >= E, "R4 spacing", cyc - edge_t[edges-1], E);
          lim = imax(lim, edge_t[edges-1] + E);
        end
        if (edges >= 2) begin
          chk(cyc - edge_t[edges-2] >= P, "R5 same direction", cyc - edge_t[edges-2], P);
          lim = imax(lim, edge_t[edges-2] + P);
        end
        chk(cyc == lim, "R8 earliest allowed edge", cyc, lim);
        if (edges < 16) edge_t[edges] = cyc;
        edges++;
      end
      if (data_o !== prev_data && edges > 0)
        chk(cyc - edge_t[edges-1] >= H, "R6 hold", cyc - edge_t[edges-1], H);
      if (in_ready_o && edges > 0 && edges < n_words)
        chk(cyc + 1 - edge_t[edges-1] >= H, "R6 ready after hold", cyc + 1 - edge_t[edges-1], H);
      if (done_o) begin
        chk(!done_seen, "R9 single done", 1, 0);
        chk(cyc == edge_t[n_words-1] + H, "R9 done timing", cyc, edge_t[n_words-1] + H);
        chk(strobe_o == 1'b1, "R9 strobe high at done", int'(strobe_o), 1);
        chk(edges == n_words, "R2 transition count", edges, n_words);
        done_seen = 1;
        done_cyc  = cyc;
      end
    end
    prev_strobe = strobe_o;
    prev_data   = data_o;
    if (src_fire) src_idx++;
    in_valid = src_on && (src_idx < n_words) && (!stall || (cyc % 64) >= 40);
    in_data  = word(burst_id, src_idx);
    src_fire = in_valid && in_ready_o;
    if (src_fire) last_load = cyc + 1;
    if (mon_on && stall && in_ready_o && !in_valid) begin
      watch    = 1;
      w_strobe = strobe_o;
      w_data   = data_o;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_burst(input int m, input int n, input bit stl, input bit disturb);
    int t0;
    int k [16];
    @(negedge clk);
    burst_id++;
    n_words = n; stall = stl;
    E = need(m, 0); P = need(m, 1); S = need(m, 2); H = need(m, 3);
    edges = 0; done_seen = 0; src_idx = 0; src_fire = 0; last_load = 0;
    src_on = 1; mon_on = 1;
    start_i = 1'b1; mode_i = 2'(m); count_i = CW'(n);
    t0 = cyc + 1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      mode_i = 2'd0;
      repeat (5) @(negedge clk);
      start_i = 1'b1; count_i = 8'd9;          // R10: must be ignored
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int i = 0; i < 6000 && !done_seen; i++) @(negedge clk);
    chk(done_seen, "R9 done reached", int'(done_seen), 1);
    if (!stl && done_seen) begin
      k[0] = 1 + S;
      for (int i = 1; i < n; i++) begin
        k[i] = imax(k[i-1] + H + S, k[i-1] + E);
        if (i >= 2) k[i] = imax(k[i], k[i-2] + P);
      end
      for (int i = 0; i < n; i++)
        chk(edge_t[i] - t0 == k[i], disturb ? "R10 timing from captured mode" : "R7 schedule",
            edge_t[i] - t0, k[i]);
      chk(done_cyc - t0 == k[n-1] + H, "R7 done on schedule", done_cyc - t0, k[n-1] + H);
    end
    repeat (2) @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", int'(done_o), 0);
    chk(strobe_o == 1'b1, "R2 idle high after burst", int'(strobe_o), 1);
    chk(edges == n, disturb ? "R10 restart ignored" : "R2 edges per burst", edges, n);
    src_on = 0; mon_on = 0; mode_i = 2'd0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(strobe_o == 1'b1, "R1 strobe idle", int'(strobe_o), 1);
    chk(data_o == '0, "R1 bus zero", int'(data_o), 0);
    chk(done_o == 1'b0, "R1 done low", int'(done_o), 0);
    chk(in_ready_o == 1'b0, "R1 ready low", int'(in_ready_o), 0);

    // R11: zero-length start
    begin
      bit bad;
      bad = 0;
      start_i = 1'b1; count_i = '0; mode_i = 2'd1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 12; i++) begin
        if (in_ready_o || !strobe_o || done_o) bad = 1;
        @(negedge clk);
      end
      chk(!bad, "R11 zero count ignored", int'(bad), 0);
    end

    // R12: derived counts never below one
    for (int m = 0; m < 4; m++)
      for (int kd = 0; kd < 4; kd++)
        chk(need(m, kd) >= 1, "R12 count at least one", need(m, kd), 1);

    for (int m = 0; m < 4; m++)
      for (int n = 1; n <= 4; n++)
        for (int s = 0; s < 2; s++)
          run_burst(m, n, s[0], 1'b0);

    run_burst(2, 3, 1'b0, 1'b1);
    run_burst(1, 4, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule